// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block collects up to 256 peripheral interrupt lines (64 by default) into a three-level status tree and presents it to a host through a byte-wide register window. Lines are grouped eight to a block, and blocks eight to a master. A pending line marks its block. A marked block marks its master. Any marked master marks the root, which drives a single summary interrupt to the host.

Software reads the root register first, then the master registers it names, and then the individual blocks. Block data is reached indirectly. Software writes a block index into a select register. It then reads either the latched pending bits or the live input levels of that block. A configuration byte port carries writes to the per-line trigger logic, which lies outside this block, and returns that logic's readback. The per-line pending and raw vectors come from that trigger logic.

Top module: `irq_tree_agg`

## Requirements
- R1: After reset, the read data output is 0, the block-select register reads 0 and the configuration strobe is low.
- R2: A write to offset 5 loads the block-select register with wdata. A read of offset 5 returns the stored value.
- R3: A read of offset 6 returns the 8 pending bits of the selected block. Line n appears in block n/8 at bit n%8.
- R4: A read of offset 8 returns the raw input levels of the 8 lines in the selected block. The pending state of those lines has no effect on this value.
- R5: A read of offset 1+m (m = 0..3) returns master m. Bit i of master m is set when any line of block 8*m+i is pending. Bits of blocks that are not implemented read 0.
- R6: A read of offset 0 returns the root. Bit m+1 is set when master m has any bit set. Bit 0 is the OR of all master bits. Bits 7..5 read 0.
- R7: irq_out is high exactly when some line is pending, which is the same condition as root bit 0.
- R8: When the select value is at or beyond the number of implemented blocks, reads of offsets 6 and 8 return 0.
- R9: Read data appears one cycle after rd_en and holds until the next read.
- R10: A write to offset 7 raises cfg_wr for one cycle on the next edge. In that cycle cfg_wdata carries wdata and cfg_blk carries the select value. A read of offset 7 returns cfg_rdata.
- R11: Writes to offsets other than 5 and 7 change nothing. Reads of offsets 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| line_pend | input | NUM_LINES | Latched pending bit of each line |
| line_raw | input | NUM_LINES | Raw level of each line |
| cfg_wr | output | 1 | Configuration write pulse |
| cfg_blk | output | 8 | Block index for the configuration write |
| cfg_wdata | output | 8 | Configuration write byte |
| cfg_rdata | input | 8 | Configuration readback from trigger logic |
| irq_out | output | 1 | Summary interrupt |

## Verification
The hardest cases to reach are the edges of the index mapping. These are lines at bit 7 of the last implemented block, master registers that cover no implemented block, and select values one past the last block. The stimulus table places single pending or raw bits at these positions, including line 63 and line 15. It then writes the select register before each read, so every read goes through the select path with a value just set. Directed writes to read-only and unused offsets follow. Each is followed by a read back of the select register and the block data, which shows that nothing changed.

// File: rtl/irq_tree_agg.sv
module irq_tree_agg #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           addr,
  input  logic [7:0]           wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [7:0]           rdata,
  input  logic [NUM_LINES-1:0] line_pend,
  input  logic [NUM_LINES-1:0] line_raw,
  output logic                 cfg_wr,
  output logic [7:0]           cfg_blk,
  output logic [7:0]           cfg_wdata,
  input  logic [7:0]           cfg_rdata,
  output logic                 irq_out
);
  localparam int NUM_BLOCKS  = (NUM_LINES + 7) / 8;
  localparam int NUM_MASTERS = (NUM_BLOCKS + 7) / 8;
  localparam int PAD_W       = NUM_BLOCKS * 8;
  localparam int MAX_MASTERS = 4;

  logic [PAD_W-1:0]          pend_w, raw_w;
  logic [NUM_BLOCKS-1:0]     blk_any;
  logic [8*MAX_MASTERS-1:0]  mst;
  logic [7:0]                root, sel_q, blk_pend, blk_raw, rd_mux;

  assign pend_w = PAD_W'(line_pend);
  assign raw_w  = PAD_W'(line_raw);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign blk_any[b] = |pend_w[b*8 +: 8];
  end

  for (genvar m = 0; m < MAX_MASTERS; m++) begin : g_mst
    for (genvar i = 0; i < 8; i++) begin : g_bit
      if (m*8 + i < NUM_BLOCKS) begin : g_on
        assign mst[m*8+i] = blk_any[m*8+i];
      end else begin : g_off
        assign mst[m*8+i] = 1'b0;
      end
    end
  end

  assign root = {3'b000, |mst[31:24], |mst[23:16], |mst[15:8], |mst[7:0], |mst};
  assign irq_out = root[0];

  always_comb begin
    blk_pend = '0;
    blk_raw  = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (sel_q == 8'(b)) begin
        blk_pend = pend_w[b*8 +: 8];
        blk_raw  = raw_w[b*8 +: 8];
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rd_mux = root;
      4'd1:    rd_mux = mst[7:0];
      4'd2:    rd_mux = mst[15:8];
      4'd3:    rd_mux = mst[23:16];
      4'd4:    rd_mux = mst[31:24];
      4'd5:    rd_mux = sel_q;
      4'd6:    rd_mux = blk_pend;
      4'd7:    rd_mux = cfg_rdata;
      4'd8:    rd_mux = blk_raw;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      rdata     <= '0;
      cfg_wr    <= 1'b0;
      cfg_blk   <= '0;
      cfg_wdata <= '0;
    end else begin
      cfg_wr <= wr_en && addr == 4'd7;
      if (wr_en && addr == 4'd5) sel_q <= wdata;
      if (wr_en && addr == 4'd7) begin
        cfg_blk   <= sel_q;
        cfg_wdata <= wdata;
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, NUM_MASTERS[0]};
endmodule

// File: rtl/irq_tree_agg_chk.sv
module irq_tree_agg_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           addr,
  input logic [7:0]           wdata,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [7:0]           rdata,
  input logic                 irq_out,
  input logic                 cfg_wr,
  input logic [7:0]           cfg_wdata,
  input logic [7:0]           sel_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(rd_en) |-> $stable(rdata));

  assert_root_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(rd_en && addr == 4'd0) |-> rdata[0] == $past(irq_out));

  assert_root_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(rd_en && addr == 4'd0) |-> rdata[7:5] == 3'b000);

  assert_cfg_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cfg_wr == $past(wr_en && addr == 4'd7));

  assert_cfg_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cfg_wr |-> cfg_wdata == $past(wdata));

  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(wr_en && addr == 4'd5) |-> $stable(sel_q));

  assert_unused_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(rd_en && addr > 4'd8) |-> rdata == 8'h00);
endmodule

bind irq_tree_agg irq_tree_agg_chk #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/sim_irq_tree_agg.sv
module sim_irq_tree_agg;
  localparam int N = 64;
  localparam int NV = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, cfg_rdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [N-1:0] line_pend = '0, line_raw = '0;
  logic [7:0] rdata, cfg_blk, cfg_wdata;
  logic cfg_wr, irq_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_tree_agg #(.NUM_LINES(N)) u0 (.*);

  // {pend, raw, sel, addr, expected}
  localparam logic [147:0] VECS [0:NV-1] = '{
    {64'h0000_0000_0000_0001, 64'h0, 8'd0, 4'd6, 8'h01},
    {64'h0000_0000_0000_8000, 64'h0, 8'd1, 4'd6, 8'h80},
    {64'h0000_0000_0000_8000, 64'h0, 8'd0, 4'd6, 8'h00},
    {64'h8000_0000_0000_0000, 64'h0, 8'd7, 4'd6, 8'h80},
    {64'h0, 64'h0000_00A5_0000_0000, 8'd4, 4'd8, 8'hA5},
    {64'h0000_0100_0000_0001, 64'h0, 8'd0, 4'd1, 8'h21},
    {64'h0000_0100_0000_0001, 64'h0, 8'd0, 4'd0, 8'h03},
    {64'h0, 64'h0, 8'd0, 4'd0, 8'h00},
    {64'hFF00_0000_0000_0000, 64'h0, 8'd0, 4'd1, 8'h80},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd0, 4'd2, 8'h00},
    {64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd9, 4'd8, 8'h00},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd8, 4'd6, 8'h00},
    {64'h0, 64'h0, 8'h3C, 4'd5, 8'h3C},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd0, 4'd12, 8'h00},
    {64'h0000_0000_0000_00FF, 64'h0, 8'd0, 4'd8, 8'h00}
  };
  localparam string VTAG [0:NV-1] = '{"R3","R3","R3","R3","R4","R5","R6","R6",
                                       "R5","R5","R8","R8","R2","R11","R4"};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 cfg_wr", cfg_wr, 0);
    rd(4'd5, d); chk("R1 sel", d, 0);

    for (int k = 0; k < NV; k++) begin
      line_pend = VECS[k][147:84];
      line_raw  = VECS[k][83:20];
      wr(4'd5, VECS[k][19:12]);
      rd(VECS[k][11:8], d);
      chk(VTAG[k], d, VECS[k][7:0]);
      chk("R7 irq", irq_out, |VECS[k][147:84]);
    end

    // R9: data appears after one strobe and holds without one
    line_pend = 64'h1; wr(4'd5, 8'd0);
    rd(4'd6, d); chk("R9 read", d, 8'h01);
    line_pend = 64'h0; repeat (3) @(negedge clk);
    chk("R9 hold", rdata, 8'h01);

    // R10 configuration pass-through
    wr(4'd5, 8'd3);
    @(negedge clk); addr = 4'd7; wdata = 8'h5A; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 pulse", cfg_wr, 1);
    chk("R10 data", cfg_wdata, 8'h5A);
    chk("R10 blk", cfg_blk, 8'd3);
    @(negedge clk); chk("R10 one cycle", cfg_wr, 0);
    cfg_rdata = 8'hC3;
    rd(4'd7, d); chk("R10 readback", d, 8'hC3);

    // R11 writes to other offsets are ignored
    line_pend = 64'h0000_0000_0000_0600;
    wr(4'd5, 8'd1);
    wr(4'd6, 8'hFF); wr(4'd0, 8'hFF); wr(4'd8, 8'hFF); wr(4'd12, 8'h02);
    chk("R11 no cfg pulse", cfg_wr, 0);
    rd(4'd5, d); chk("R11 sel kept", d, 8'd1);
    rd(4'd6, d); chk("R11 pend kept", d, 8'h06);
    rd(4'd15, d); chk("R11 unused", d, 8'h00);
    rd(4'd1, d); chk("R5 master", d, 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule